// File: doc/BRIEF.md
# Floppy Head Positioning Sequencer

This block runs the head-movement group of a floppy disk controller's commands. It can return the head to track zero, move it to a target track, or take one step inward, outward or in the same direction as the last step. The host presents an 8-bit command byte with a one-cycle start strobe. It also supplies the seek target on the data register input, and it can load the track register while the block is idle.

The sequencer sends one-clock step pulses to the drive, with a direction level. Between pulses it waits the programmed step interval, which it counts in ticks of a 1 ms timebase. Seeks and optional step updates keep the track register aligned with the head. When the verify bit is set, a fixed head-settle wait runs after the movement. Busy stays high for the whole sequence, and a one-cycle done pulse marks its last cycle.

Top module: `head_pos_seq`

## Requirements
- R1: After reset the block is in this state: busy_o=0, step_o=0, done_o=0, seek_err_o=0, track_o=0 and dir_o=1 (inward).
- R2: Command bits [7:4] are decoded as follows. 0000 is restore, 0001 is seek, 001u is step in the last direction, 010u is step in and 011u is step out. Any byte with bit 7 set is not accepted: busy_o stays 0 and no step pulse is issued.
- R3: busy_o rises in the cycle after an accepted start strobe. A start strobe that arrives while busy_o=1 has no effect on the running command.
- R4: step_o is high for one clock at a time and only while busy_o=1. dir_o=1 means inward (track number increasing) and dir_o=0 means outward.
- R5: Command bits [1:0] select the step interval, counted in timebase ticks. With the default table, codes 00/01/10/11 give 6/12/20/30 ticks. With FAST_RATES=1 they give 6/12/2/3 ticks. The first pulse of a command sees no ticks before it. Between two pulses of the same command, exactly the interval's number of ticks occurs.
- R6: Step-in issues one step with dir_o=1 and step-out issues one step with dir_o=0. A plain step reuses the current direction. With bit 4 set, track_o moves by one in the step direction; with bit 4 clear, track_o is unchanged.
- R7: A seek latches data_reg at start. It steps toward that value, updating track_o by one per pulse, until track_o equals it. If they are already equal, no pulse is issued.
- R8: A restore steps outward without changing track_o until trk0_i is high, then loads 0 into track_o. If trk0_i is already high, no pulse is issued.
- R9: If trk0_i has not appeared after RESTORE_LIMIT (default 255) restore pulses, the command ends with seek_err_o=1 and track_o unchanged. seek_err_o is cleared at the next accepted command.
- R10: With command bit 2 set, an extra SETTLE_MS (default 30) ticks are waited before done, after the last interval (or from the start if there was no pulse).
- R11: done_o is high for exactly one cycle, the last cycle with busy_o=1. The wait from the last pulse to done equals the step interval plus any settle time.
- R12: not_trk0_o is the inverse of trk0_i, delayed by one register stage.
- R13: A host track write (track_wr) loads track_wdata when the block is idle. It is ignored while busy_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle start strobe for cmd_byte |
| cmd_byte | input | 8 | Command byte |
| data_reg | input | 8 | Seek target track |
| track_wr | input | 1 | Host load strobe for the track register |
| track_wdata | input | 8 | Value for a host track load |
| trk0_i | input | 1 | Drive reports head at track zero |
| tick_1ms | input | 1 | One-cycle 1 ms timebase tick |
| step_o | output | 1 | Step pulse to the drive |
| dir_o | output | 1 | Step direction, 1 = inward |
| track_o | output | 8 | Track register |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle end-of-command pulse |
| not_trk0_o | output | 1 | Registered inverse of trk0_i |
| seek_err_o | output | 1 | Restore gave up without finding track zero |

## Verification
The assertions check, on every cycle, the properties that can be judged locally. Step pulses are single and occur only while busy. Every track update is exactly one in the step direction, and the track holds still unless a step, a zero load or an idle host write occurs. Busy follows an accepted start, done is followed by idle, and the error flag rises only with done. The bench scenarios cover what depends on history and counting. These are the tick spacing for each rate code, the settle addition, the seek's stopping point and direction choice, the reuse of the last direction, the restore give-up after the full step budget, and the commands or writes that must be ignored.

// File: rtl/hps_pkg.sv
package hps_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECIDE,
    ST_STEP,
    ST_WAIT,
    ST_SETTLE,
    ST_FINISH
  } hps_state_e;

  typedef enum logic [2:0] {
    OP_RESTORE,
    OP_SEEK,
    OP_STEP,
    OP_STEP_IN,
    OP_STEP_OUT,
    OP_NONE
  } hps_op_e;

  typedef struct packed {
    hps_op_e    op;
    logic       upd;
    logic       verify;
    logic [1:0] rate;
  } hps_cmd_t;

  // Step interval in ticks for a rate code; fast selects the alternate table.
  function automatic logic [7:0] step_interval_ms(input logic [1:0] code, input logic fast);
    logic [7:0] r;
    case (code)
      2'd0:    r = 8'd6;
      2'd1:    r = 8'd12;
      2'd2:    r = fast ? 8'd2 : 8'd20;
      default: r = fast ? 8'd3 : 8'd30;
    endcase
    return r;
  endfunction

  function automatic hps_cmd_t decode_cmd(input logic [7:0] b);
    hps_cmd_t c;
    c.upd    = b[4];
    c.verify = b[2];
    c.rate   = b[1:0];
    if (b[7]) begin
      c.op = OP_NONE;
    end else begin
      case (b[6:5])
        2'b00:   c.op = b[4] ? OP_SEEK : OP_RESTORE;
        2'b01:   c.op = OP_STEP;
        2'b10:   c.op = OP_STEP_IN;
        default: c.op = OP_STEP_OUT;
      endcase
    end
    return c;
  endfunction

  // Track value after one step in direction dir (1 = inward).
  function automatic logic [7:0] track_next(input logic [7:0] t, input logic dir);
    return dir ? t + 8'd1 : t - 8'd1;
  endfunction

endpackage

// File: rtl/hps_decode.sv
module hps_decode
  import hps_pkg::*;
(
  input  logic [7:0] cmd_byte,
  output hps_cmd_t   cmd_o,
  output logic       op_valid
);

  assign cmd_o    = decode_cmd(cmd_byte);
  assign op_valid = (cmd_o.op != OP_NONE);

endmodule

// File: rtl/hps_tick_timer.sv
module hps_tick_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         expire
);

  logic [W-1:0] cnt_q;

  assign expire = run && tick && (cnt_q == limit - W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || expire) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + W'(1);
    end
  end

endmodule

// File: rtl/hps_track_unit.sv
module hps_track_unit
  import hps_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic [7:0] host_data,
  input  logic       zero_load,
  input  logic       step_upd,
  input  logic       dir_load,
  input  logic       dir_val,
  output logic [7:0] track_o,
  output logic       dir_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      track_o <= '0;
    end else if (zero_load) begin
      track_o <= '0;
    end else if (step_upd) begin
      track_o <= track_next(track_o, dir_o);
    end else if (host_wr) begin
      track_o <= host_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_o <= 1'b1;
    end else if (dir_load) begin
      dir_o <= dir_val;
    end
  end

endmodule

// File: rtl/head_pos_seq.sv
module head_pos_seq
  import hps_pkg::*;
#(
  parameter bit FAST_RATES    = 1'b0,
  parameter int SETTLE_MS     = 30,
  parameter int RESTORE_LIMIT = 255,
  parameter int TIMER_W       = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  input  logic [7:0] data_reg,
  input  logic       track_wr,
  input  logic [7:0] track_wdata,
  input  logic       trk0_i,
  input  logic       tick_1ms,
  output logic       step_o,
  output logic       dir_o,
  output logic [7:0] track_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       not_trk0_o,
  output logic       seek_err_o
);

  localparam int CNT_W = $clog2(RESTORE_LIMIT + 1);
  localparam logic [CNT_W-1:0]   LIMIT_C  = CNT_W'(RESTORE_LIMIT);
  localparam logic [TIMER_W-1:0] SETTLE_L = TIMER_W'(SETTLE_MS);

  hps_state_e       state_q, state_d;
  hps_cmd_t         cmd_q, cmd_dec;
  logic [7:0]       target_q;
  logic             moved_q;
  logic [CNT_W-1:0] rcnt_q;
  logic             op_valid;

  // Named internal events
  logic ev_accept;
  logic ev_expire;
  logic ev_zero_load;
  logic ev_track_upd;
  logic ev_err_set;
  logic dir_load;
  logic dir_val;
  logic timer_run;
  logic host_wr_ok;
  logic [TIMER_W-1:0] timer_limit;
  hps_state_e post_state;

  hps_decode u_decode (
    .cmd_byte (cmd_byte),
    .cmd_o    (cmd_dec),
    .op_valid (op_valid)
  );

  assign ev_accept  = (state_q == ST_IDLE) && cmd_valid && op_valid;
  assign host_wr_ok = track_wr && (state_q == ST_IDLE);
  assign timer_run  = (state_q == ST_WAIT) || (state_q == ST_SETTLE);
  assign timer_limit = (state_q == ST_SETTLE) ? SETTLE_L
                       : TIMER_W'(step_interval_ms(cmd_q.rate, FAST_RATES));
  assign post_state = cmd_q.verify ? ST_SETTLE : ST_FINISH;

  hps_tick_timer #(.W(TIMER_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (timer_run),
    .tick   (tick_1ms),
    .limit  (timer_limit),
    .expire (ev_expire)
  );

  assign ev_track_upd = (state_q == ST_STEP) &&
                        ((cmd_q.op == OP_SEEK) ||
                         (cmd_q.upd && (cmd_q.op == OP_STEP ||
                                        cmd_q.op == OP_STEP_IN ||
                                        cmd_q.op == OP_STEP_OUT)));

  hps_track_unit u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_wr   (host_wr_ok),
    .host_data (track_wdata),
    .zero_load (ev_zero_load),
    .step_upd  (ev_track_upd),
    .dir_load  (dir_load),
    .dir_val   (dir_val),
    .track_o   (track_o),
    .dir_o     (dir_o)
  );

  always_comb begin
    state_d      = state_q;
    dir_load     = 1'b0;
    dir_val      = dir_o;
    ev_zero_load = 1'b0;
    ev_err_set   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (ev_accept) state_d = ST_DECIDE;
      end
      ST_DECIDE: begin
        case (cmd_q.op)
          OP_RESTORE: begin
            if (trk0_i) begin
              ev_zero_load = 1'b1;
              state_d      = post_state;
            end else if (rcnt_q == LIMIT_C) begin
              ev_err_set = 1'b1;
              state_d    = ST_FINISH;
            end else begin
              dir_load = 1'b1;
              dir_val  = 1'b0;
              state_d  = ST_STEP;
            end
          end
          OP_SEEK: begin
            if (track_o == target_q) begin
              state_d = post_state;
            end else begin
              dir_load = 1'b1;
              dir_val  = (target_q > track_o);
              state_d  = ST_STEP;
            end
          end
          default: begin
            if (moved_q) begin
              state_d = post_state;
            end else begin
              state_d = ST_STEP;
              if (cmd_q.op == OP_STEP_IN) begin
                dir_load = 1'b1;
                dir_val  = 1'b1;
              end else if (cmd_q.op == OP_STEP_OUT) begin
                dir_load = 1'b1;
                dir_val  = 1'b0;
              end
            end
          end
        endcase
      end
      ST_STEP:   state_d = ST_WAIT;
      ST_WAIT:   if (ev_expire) state_d = ST_DECIDE;
      ST_SETTLE: if (ev_expire) state_d = ST_FINISH;
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cmd_q      <= '{op: OP_NONE, upd: 1'b0, verify: 1'b0, rate: 2'b00};
      target_q   <= '0;
      moved_q    <= 1'b0;
      rcnt_q     <= '0;
      seek_err_o <= 1'b0;
      not_trk0_o <= 1'b0;
    end else begin
      state_q    <= state_d;
      not_trk0_o <= !trk0_i;
      if (ev_accept) begin
        cmd_q      <= cmd_dec;
        target_q   <= data_reg;
        moved_q    <= 1'b0;
        rcnt_q     <= '0;
        seek_err_o <= 1'b0;
      end else begin
        if (state_q == ST_STEP) begin
          moved_q <= 1'b1;
          rcnt_q  <= rcnt_q + CNT_W'(1);
        end
        if (ev_err_set) seek_err_o <= 1'b1;
      end
    end
  end

  assign step_o = (state_q == ST_STEP);
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_FINISH);

endmodule

// File: rtl/hps_checker.sv
module hps_checker
  import hps_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       track_wr,
  input logic [7:0] track_o,
  input logic       step_o,
  input logic       dir_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       seek_err_o,
  input logic       ev_accept,
  input logic       ev_zero_load,
  input logic       ev_track_upd
);

  a_r4_step_single: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |=> !step_o);

  a_r4_step_busy: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |-> busy_o);

  a_r3_busy_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> busy_o);

  a_r3_no_accept_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !ev_accept);

  a_r11_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!busy_o && !done_o));

  a_r6_track_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    ev_track_upd |=> (track_o == track_next($past(track_o), $past(dir_o))));

  a_r13_track_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_track_upd && !ev_zero_load && !(track_wr && !busy_o)) |=> $stable(track_o));

  a_r9_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seek_err_o) |-> done_o);

endmodule

bind head_pos_seq hps_checker u_hps_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .track_wr     (track_wr),
  .track_o      (track_o),
  .step_o       (step_o),
  .dir_o        (dir_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .seek_err_o   (seek_err_o),
  .ev_accept    (ev_accept),
  .ev_zero_load (ev_zero_load),
  .ev_track_upd (ev_track_upd)
);

// File: tb/head_pos_seq_bench.sv
module head_pos_seq_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic [7:0] data_reg = 8'h00;
  logic       track_wr = 1'b0;
  logic [7:0] track_wdata = 8'h00;
  logic       trk0_i;
  logic       tick_1ms = 1'b0;
  logic       step_o, dir_o, busy_o, done_o, not_trk0_o, seek_err_o;
  logic [7:0] track_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  head_pos_seq u_head_pos_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .data_reg(data_reg), .track_wr(track_wr), .track_wdata(track_wdata),
    .trk0_i(trk0_i), .tick_1ms(tick_1ms), .step_o(step_o), .dir_o(dir_o),
    .track_o(track_o), .busy_o(busy_o), .done_o(done_o),
    .not_trk0_o(not_trk0_o), .seek_err_o(seek_err_o)
  );

  // Timebase: one tick every 4 cycles
  int ph = 0;
  always @(negedge clk) begin
    ph = (ph + 1) % 4;
    tick_1ms = (ph == 0);
  end

  int tick_total = 0;
  always @(posedge clk) if (tick_1ms) tick_total <= tick_total + 1;

  // Drive model: head position relative to a base set by the driver
  int net_steps = 0;
  int head_base = 0;
  int base_mark = 0;
  logic no_trk0 = 1'b0;
  always @(negedge clk) if (step_o) net_steps = net_steps + (dir_o ? 1 : -1);
  assign trk0_i = !no_trk0 && ((head_base + net_steps - base_mark) == 0);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  typedef struct {
    bit    is_done;
    bit    dir;
    int    trk;
    bit    err;
    int    gap;
    string req;
  } sb_item_t;

  sb_item_t sb[$];

  task automatic push_step(input bit d, input int t, input int g, input string r);
    sb_item_t it;
    it.is_done = 1'b0; it.dir = d; it.trk = t; it.err = 1'b0; it.gap = g; it.req = r;
    sb.push_back(it);
  endtask

  task automatic push_done(input int t, input bit e, input int g, input string r);
    sb_item_t it;
    it.is_done = 1'b1; it.dir = 1'b0; it.trk = t; it.err = e; it.gap = g; it.req = r;
    sb.push_back(it);
  endtask

  // Monitor: pops expected items as step and done pulses appear
  bit       prev_busy = 1'b0;
  bit       pend = 1'b0;
  int       pend_trk = 0;
  string    pend_req = "";
  int       anchor = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_busy = 1'b0;
      pend = 1'b0;
    end else begin
      sb_item_t it;
      int gap;
      if (pend) begin
        chk({pend_req, " track after step"}, int'(track_o), pend_trk);
        pend = 1'b0;
      end
      if (busy_o && !prev_busy) anchor = tick_total;
      if (step_o) begin
        gap = tick_total - anchor;
        anchor = tick_total;
        if (sb.size() == 0) begin
          chk("R4 unexpected step pulse", 1, 0);
        end else begin
          it = sb.pop_front();
          chk({it.req, " item kind is step"}, int'(it.is_done), 0);
          chk({it.req, " direction"}, int'(dir_o), int'(it.dir));
          chk("R5 ticks before step", gap, it.gap);
          pend = 1'b1;
          pend_trk = it.trk;
          pend_req = it.req;
        end
      end
      if (done_o) begin
        gap = tick_total - anchor;
        if (sb.size() == 0) begin
          chk("R11 unexpected done pulse", 1, 0);
        end else begin
          it = sb.pop_front();
          chk({it.req, " item kind is done"}, int'(it.is_done), 1);
          chk({it.req, " final track"}, int'(track_o), it.trk);
          chk("R9 seek error flag", int'(seek_err_o), int'(it.err));
          chk("R10 R11 ticks before done", gap, it.gap);
        end
      end
      prev_busy = busy_o;
    end
  end

  task automatic issue_raw(input logic [7:0] c);
    @(posedge clk);
    while (ph != 0) @(posedge clk);
    @(negedge clk);
    cmd_byte  = c;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic issue(input logic [7:0] c);
    issue_raw(c);
    chk("R3 busy after start", int'(busy_o), 1);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy_o || sb.size() != 0) @(negedge clk);
  endtask

  task automatic set_head(input int p);
    head_base = p;
    base_mark = net_steps;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 step", int'(step_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 error", int'(seek_err_o), 0);
    chk("R1 track", int'(track_o), 0);
    chk("R1 dir", int'(dir_o), 1);

    // R13 idle host write
    track_wr = 1'b1; track_wdata = 8'd5;
    @(negedge clk);
    track_wr = 1'b0;
    chk("R13 idle track write", int'(track_o), 5);

    // R8 restore from head position 3, rate 6
    set_head(3);
    push_step(1'b0, 5, 0, "R8");
    push_step(1'b0, 5, 6, "R8");
    push_step(1'b0, 5, 6, "R8");
    push_done(0, 1'b0, 6, "R8");
    issue(8'h00);
    wait_idle();

    // R7 seek inward to 4, rate 12, verify (R10)
    data_reg = 8'd4;
    for (int t = 1; t <= 4; t++) push_step(1'b1, t, (t == 1) ? 0 : 12, "R7");
    push_done(4, 1'b0, 12 + 30, "R10");
    issue(8'h15);
    wait_idle();

    // R7 seek to current track: no step
    push_done(4, 1'b0, 0, "R7");
    issue(8'h10);
    wait_idle();

    // R7 seek outward to 1, rate 30
    data_reg = 8'd1;
    push_step(1'b0, 3, 0, "R7");
    push_step(1'b0, 2, 30, "R7");
    push_step(1'b0, 1, 30, "R7");
    push_done(1, 1'b0, 30, "R5");
    issue(8'h13);
    wait_idle();

    // R6 step-out with update, rate 20
    push_step(1'b0, 0, 0, "R6");
    push_done(0, 1'b0, 20, "R5");
    issue(8'h72);
    wait_idle();

    // R6 step-in without update
    push_step(1'b1, 0, 0, "R6");
    push_done(0, 1'b0, 6, "R6");
    issue(8'h40);
    wait_idle();

    // R6 plain step repeats inward, with update
    push_step(1'b1, 1, 0, "R6");
    push_done(1, 1'b0, 6, "R6");
    issue(8'h30);
    wait_idle();

    // R2 command with bit 7 set is not accepted
    issue_raw(8'h80);
    for (int i = 0; i < 6; i++) begin
      chk("R2 busy stays low", int'(busy_o), 0);
      chk("R2 no step", int'(step_o), 0);
      @(negedge clk);
    end
    chk("R2 track unchanged", int'(track_o), 1);

    // R3 / R13: start strobe and track write during busy are ignored
    data_reg = 8'd3;
    push_step(1'b1, 2, 0, "R3");
    push_step(1'b1, 3, 6, "R13");
    push_done(3, 1'b0, 6, "R3");
    issue(8'h10);
    @(negedge clk);
    cmd_byte = 8'h00; cmd_valid = 1'b1;
    track_wr = 1'b1; track_wdata = 8'h77;
    @(negedge clk);
    cmd_valid = 1'b0; track_wr = 1'b0;
    wait_idle();

    // R12 head away from track zero
    repeat (2) @(negedge clk);
    chk("R12 not track zero high", int'(not_trk0_o), 1);

    // R9 restore never finds track zero
    no_trk0 = 1'b1;
    for (int n = 0; n < 255; n++) push_step(1'b0, 3, (n == 0) ? 0 : 6, "R9");
    push_done(3, 1'b1, 6, "R9");
    issue(8'h00);
    wait_idle();

    // R12 head back at track zero
    no_trk0 = 1'b0;
    set_head(0);
    repeat (2) @(negedge clk);
    chk("R12 not track zero low", int'(not_trk0_o), 0);

    // R8 / R10 restore at track zero with verify; error flag cleared
    push_done(0, 1'b0, 30, "R8");
    issue(8'h04);
    wait_idle();

    repeat (4) @(negedge clk);
    chk("R11 busy low at end", int'(busy_o), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule